// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-side protocol engine of a 2048-byte serial memory. It watches a two-wire bus through an SCL input and an SDA input, and pulls SDA low through an open-drain enable. It finds start and stop conditions and checks the device select byte. Three memory address bits come from that byte. The block acknowledges bytes and moves data between the bus and a simple byte port. A separate write controller and storage array sit on the other side of that port.

The master chooses the address in a write-mode transfer. Data bytes that follow the address are stored one by one. A stop that ends a transfer with data raises a one-cycle commit pulse to the write controller. The controller reports its self-timed write cycle back on a busy input. While busy is high the engine acknowledges no select byte, so the master can poll until the write is done. Reads return bytes from a persistent address counter, MSB first. They continue for as long as the master acknowledges each byte.

Top module: `twm_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start, and a rising SDA while SCL is high is a stop. A stop releases SDA and returns the engine to idle.
- R2: After a start, the first byte is a select byte. If its top four bits are 1010 and busy is low, the engine pulls SDA low for the whole ninth clock. Otherwise it never drives SDA until the next start.
- R3: Select byte bits 3..1 become memory address bits 10..8. Bit 0 selects read (1) or write (0).
- R4: In a write-mode transfer, the byte after the select byte sets address bits 7..0 and is acknowledged.
- R5: Each later byte of a write-mode transfer is acknowledged and gives one write strobe, with the current address and the byte. The low four address bits then advance, wrapping inside the 16-byte page; the upper bits do not change.
- R6: A stop after at least one stored data byte gives exactly one commit pulse. A stop with no stored data gives none.
- R7: While busy is high, no select byte is acknowledged.
- R8: In a read, the byte at the current address is sent MSB first, and SDA changes only after an SCL falling edge. Each byte sent advances the address by one, wrapping from 2047 to 0.
- R9: An acknowledge from the master makes the engine send the next byte. A missing acknowledge releases SDA and leaves the engine idle.
- R10: The address counter keeps its value between transfers. A current-address read returns the byte one past the last one accessed, with bits 10..8 taken from the new select byte.
- R11: A start in the middle of a byte aborts the transfer and restarts the bit count, so the next select byte is decoded correctly.
- R12: After reset SDA is released, the address is 0 and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low |
| mem_addr | output | 11 | Address of the byte port |
| mem_we | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Byte to store |
| mem_rdata | input | 8 | Byte read at mem_addr |
| wr_commit | output | 1 | One-cycle pulse that starts the timed write |
| wr_busy | input | 1 | High while the timed write runs |

## Verification
Some rules are checked on every cycle. No select byte is acknowledged while busy. Start and stop reset the engine. SDA changes only after an SCL fall or a bus condition. A page write keeps the upper address bits. A read step adds exactly one to the address. Other behaviour can only be seen in the bench scenarios. These are address decoding, where the upper bits come from, wrap points, the persistent counter, end of read on no-acknowledge, and recovery after an aborted byte. The bench compares each of these against a behavioural memory and pointer model.

// File: rtl/twm_pkg.sv
package twm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } twm_state_e;

   typedef enum logic [1:0] {
      K_SEL,
      K_ADDR,
      K_DATA
   } twm_kind_e;

   localparam logic [3:0] SEL_CODE = 4'b1010;
endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic [STAGES-1:0] scl_q, sda_q;
   logic scl_d, sda_d;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("twm_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_i};
         sda_q <= {sda_q[STAGES-2:0], sda_i};
         scl_d <= scl_q[STAGES-1];
         sda_d <= sda_q[STAGES-1];
      end
   end

   assign scl_s    = scl_q[STAGES-1];
   assign sda_s    = sda_q[STAGES-1];
   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twm_ptr.sv
module twm_ptr #(
   parameter int AW = 11,
   parameter int PW = 4,
   localparam int HW = AW - 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_hi,
   input  logic [HW-1:0] hi_val,
   input  logic          ld_lo,
   input  logic [7:0]    lo_val,
   input  logic          inc_page,
   input  logic          inc_full,
   output logic [AW-1:0] ptr
);
   generate
      if (PW < 1 || PW > 8) begin : g_bad_page
         $error("twm_ptr: PW must be 1..8");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (ld_hi) begin
         ptr[AW-1:8] <= hi_val;
      end else if (ld_lo) begin
         ptr[7:0] <= lo_val;
      end else if (inc_page) begin
         ptr[PW-1:0] <= ptr[PW-1:0] + PW'(1);
      end else if (inc_full) begin
         ptr <= ptr + AW'(1);
      end
   end

   // R5
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_page && !ld_hi && !ld_lo) |=> ptr[AW-1:PW] == $past(ptr[AW-1:PW]));

   // R8
   read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_full && !inc_page && !ld_hi && !ld_lo) |=> ptr == $past(ptr) + AW'(1));
endmodule

// File: rtl/twm_slave.sv
module twm_slave
   import twm_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int PAGE_W      = 4,
   parameter int SYNC_STAGES = 2,
   localparam int HI_W       = ADDR_W - 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              wr_commit,
   input  logic              wr_busy
);
   generate
      if (HI_W < 1 || HI_W > 3) begin : g_bad_addr
         $error("twm_slave: ADDR_W must be 9..11");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   twm_state_e st;
   twm_kind_e  kind;
   logic [3:0] cnt;
   logic [7:0] shreg, txreg;
   logic       rd, mack, wrote;
   logic       byte_end, sel_ok, ld_hi, ld_lo, tx_load;

   twm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   assign byte_end = !start_ev && !stop_ev && st == ST_RX && scl_fall && cnt == 4'd8;
   assign sel_ok   = shreg[7:4] == SEL_CODE && !wr_busy;
   assign ld_hi    = byte_end && kind == K_SEL && sel_ok;
   assign ld_lo    = byte_end && kind == K_ADDR;
   assign mem_we   = byte_end && kind == K_DATA;
   assign tx_load  = !start_ev && !stop_ev && scl_fall &&
                     ((st == ST_ACK && kind == K_SEL && rd) || (st == ST_MACK && mack));
   assign mem_wdata = shreg;

   twm_ptr #(.AW(ADDR_W), .PW(PAGE_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .ld_hi(ld_hi), .hi_val(shreg[HI_W:1]),
      .ld_lo(ld_lo), .lo_val(shreg),
      .inc_page(mem_we), .inc_full(tx_load),
      .ptr(mem_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; kind <= K_SEL; cnt <= '0; shreg <= '0; txreg <= '0;
         rd <= 1'b0; mack <= 1'b0; wrote <= 1'b0; sda_oe <= 1'b0; wr_commit <= 1'b0;
      end else begin
         wr_commit <= stop_ev && wrote;
         if (mem_we) wrote <= 1'b1;
         if (start_ev) begin
            st <= ST_RX; kind <= K_SEL; cnt <= '0; sda_oe <= 1'b0;
         end else if (stop_ev) begin
            st <= ST_IDLE; sda_oe <= 1'b0; wrote <= 1'b0;
         end else begin
            case (st)
               ST_RX: begin
                  if (scl_rise && cnt != 4'd8) begin
                     shreg <= {shreg[6:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end else if (byte_end) begin
                     if (kind != K_SEL || sel_ok) begin
                        sda_oe <= 1'b1;
                        st     <= ST_ACK;
                        if (kind == K_SEL) rd <= shreg[0];
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (tx_load) begin
                        st <= ST_TX; txreg <= mem_rdata; sda_oe <= ~mem_rdata[7];
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_RX;
                        kind   <= (kind == K_SEL) ? K_ADDR : K_DATA;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        sda_oe <= 1'b0; st <= ST_MACK;
                     end else begin
                        txreg <= {txreg[6:0], 1'b0}; sda_oe <= ~txreg[6];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     cnt <= '0;
                     if (tx_load) begin
                        st <= ST_TX; txreg <= mem_rdata; sda_oe <= ~mem_rdata[7];
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R7
   busy_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_end && kind == K_SEL && wr_busy) |=> !sda_oe);

   // R1
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (!sda_oe && st == ST_IDLE));

   // R11
   start_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (st == ST_RX && cnt == 4'd0 && kind == K_SEL));

   // R8
   drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));
endmodule

// File: tb/twm_slave_test.sv
module twm_slave_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF = 8;
   localparam int BUSY_CYC = 400;

   logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
   logic sda_oe, mem_we, wr_commit, wr_busy;
   logic [10:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata;
   logic [7:0] bmem [0:2047];
   logic [7:0] emem [0:2047];
   int busy_cnt = 0, commits = 0, strobes = 0, cycles = 0;
   int checks = 0, fails = 0;
   bit quiet = 1'b1;
   wire sda_bus = m_sda & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   twm_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .wr_commit(wr_commit), .wr_busy(wr_busy)
   );

   assign mem_rdata = bmem[mem_addr];
   assign wr_busy = busy_cnt != 0;

   always @(posedge clk) begin
      if (mem_we) begin bmem[mem_addr] <= mem_wdata; strobes <= strobes + 1; end
      if (wr_commit) begin busy_cnt <= BUSY_CYC; commits <= commits + 1; end
      else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // per-clock model: with the bus idle or the slave deselected, SDA is never driven
   always @(negedge clk) begin
      cycles++;
      if (rst_n && quiet && sda_oe) begin
         checks++; fails++;
         $display("FAIL R2 slave drove SDA while deselected: actual=1 expected=0");
      end
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic tick(int n); repeat (n) @(negedge clk); endtask

   task automatic bus_start();
      quiet = 1'b0;
      m_sda = 1'b1; tick(HALF); m_scl = 1'b1; tick(HALF);
      m_sda = 1'b0; tick(HALF); m_scl = 1'b0; tick(HALF);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(HALF); m_scl = 1'b1; tick(HALF); m_sda = 1'b1; tick(HALF);
      quiet = 1'b1; tick(HALF);
   endtask

   task automatic send_bits(logic [7:0] b, int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; tick(HALF); m_scl = 1'b1; tick(HALF); m_scl = 1'b0; tick(2);
      end
   endtask

   task automatic send_byte(logic [7:0] b, output bit acked);
      send_bits(b, 8);
      m_sda = 1'b1; tick(HALF); m_scl = 1'b1; tick(HALF/2);
      acked = (sda_bus == 1'b0);
      tick(HALF/2); m_scl = 1'b0; tick(2);
   endtask

   task automatic read_byte(output logic [7:0] b, input bit give_ack);
      m_sda = 1'b1;
      for (int i = 0; i < 8; i++) begin
         tick(HALF); m_scl = 1'b1; tick(HALF/2); b = {b[6:0], sda_bus};
         tick(HALF/2); m_scl = 1'b0; tick(2);
      end
      m_sda = ~give_ack; tick(HALF); m_scl = 1'b1; tick(HALF); m_scl = 1'b0; tick(2);
      m_sda = 1'b1;
   endtask

   task automatic wait_idle();
      while (wr_busy) tick(1);
      tick(4);
   endtask

   initial begin
      bit ack;
      logic [7:0] d;
      int sc;
      for (int i = 0; i < 2048; i++) begin
         bmem[i] = 8'(i * 7 + 3);
         emem[i] = 8'(i * 7 + 3);
      end
      tick(5);
      // R12 reset state
      chk(sda_oe == 1'b0, "R12", "sda_oe in reset", sda_oe, 0);
      chk(mem_addr == 11'd0, "R12", "address in reset", mem_addr, 0);
      chk(mem_we == 1'b0, "R12", "write strobe in reset", mem_we, 0);
      rst_n = 1'b1; tick(5);

      // byte write 0x123 <= A5 (select 1010_001_0)
      bus_start();
      send_byte(8'hA2, ack); chk(ack, "R2", "select ack", ack, 1);
      send_byte(8'h23, ack); chk(ack, "R4", "address ack", ack, 1);
      send_byte(8'hA5, ack); chk(ack, "R5", "data ack", ack, 1);
      bus_stop(); emem[12'h123] = 8'hA5;
      chk(commits == 1, "R6", "commit after data", commits, 1);
      chk(bmem[11'h123] == emem[12'h123], "R5", "stored byte", bmem[11'h123], emem[12'h123]);
      // R7 polling during busy
      chk(wr_busy, "R7", "write cycle running", wr_busy, 1);
      bus_start(); send_byte(8'hA2, ack); quiet = 1'b1;
      chk(!ack, "R7", "no ack while busy", ack, 0);
      bus_stop(); wait_idle();
      bus_start(); send_byte(8'hA2, ack);
      chk(ack, "R7", "ack once idle", ack, 1);
      bus_stop();
      chk(commits == 1, "R6", "no commit without data", commits, 1);

      // R10 current-address read continues at 0x124
      bus_start(); send_byte(8'hA3, ack); read_byte(d, 1'b0);
      chk(d == emem[12'h124], "R10", "current read", d, emem[12'h124]);
      chk(sda_oe == 1'b0, "R9", "released after no-ack", sda_oe, 0);
      bus_stop();
      // R3 upper bits from select byte: 1010_101_1 -> 0x525
      bus_start(); send_byte(8'hAB, ack); read_byte(d, 1'b0); bus_stop();
      chk(d == emem[12'h525], "R3", "upper bits from select", d, emem[12'h525]);

      // R8 random read of 0x123
      bus_start(); send_byte(8'hA2, ack); send_byte(8'h23, ack);
      bus_start(); send_byte(8'hA3, ack); read_byte(d, 1'b0); bus_stop();
      chk(d == 8'hA5, "R8", "random read", d, 8'hA5);

      // R5 page write at 0x2FE wraps to 0x2F0
      sc = strobes;
      bus_start(); send_byte(8'hA4, ack); send_byte(8'hFE, ack);
      send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
      bus_stop();
      emem[12'h2FE] = 8'h11; emem[12'h2FF] = 8'h22; emem[12'h2F0] = 8'h33;
      chk(strobes - sc == 3, "R5", "strobe count", strobes - sc, 3);
      chk(bmem[11'h2FE] == 8'h11, "R5", "page byte 0", bmem[11'h2FE], 8'h11);
      chk(bmem[11'h2FF] == 8'h22, "R5", "page byte 1", bmem[11'h2FF], 8'h22);
      chk(bmem[11'h2F0] == 8'h33, "R5", "page wrap byte", bmem[11'h2F0], 8'h33);
      chk(bmem[11'h300] == emem[12'h300], "R5", "next page untouched", bmem[11'h300], emem[12'h300]);
      wait_idle();

      // R9 sequential read 0x7FE..0x000
      bus_start(); send_byte(8'hAE, ack); send_byte(8'hFE, ack);
      bus_start(); send_byte(8'hAF, ack);
      read_byte(d, 1'b1); chk(d == emem[12'h7FE], "R9", "seq byte 0", d, emem[12'h7FE]);
      read_byte(d, 1'b1); chk(d == emem[12'h7FF], "R9", "seq byte 1", d, emem[12'h7FF]);
      read_byte(d, 1'b0); chk(d == emem[12'h000], "R8", "array wrap", d, emem[12'h000]);
      bus_stop();

      // R2 wrong code: no ack, no drive for a following byte
      sc = strobes;
      bus_start(); send_byte(8'hB2, ack); quiet = 1'b1;
      chk(!ack, "R2", "wrong code nack", ack, 0);
      send_byte(8'h00, ack); send_byte(8'h55, ack);
      chk(strobes == sc, "R2", "no strobe when deselected", strobes - sc, 0);
      bus_stop();

      // R11 abort mid-byte, then a random read decodes correctly
      bus_start(); send_bits(8'hA2, 4);
      bus_start(); send_byte(8'hA2, ack); send_byte(8'h23, ack);
      bus_start(); send_byte(8'hA3, ack); read_byte(d, 1'b0); bus_stop();
      chk(d == 8'hA5, "R11", "read after abort", d, 8'hA5);
      // R11 recovery: start, nine clocks, start, stop
      bus_start(); send_bits(8'hFF, 8); send_bits(8'hFF, 1);
      bus_start(); bus_stop();
      bus_start(); send_byte(8'hA3, ack);
      chk(ack, "R11", "ack after recovery", ack, 1);
      read_byte(d, 1'b0); bus_stop();
      chk(d == emem[12'h124], "R10", "counter persists", d, emem[12'h124]);
      chk(commits == 2, "R6", "total commits", commits, 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule